// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to sixteen maskable interrupt lines and one non-maskable line for a CPU core. Each line is watched for a low-to-high transition. A transition sets a pending bit, and the pending bit is set whether or not the line is enabled. Every maskable source has an enable bit. A global enable input gates all of them together. A fixed priority encoder then picks one source to present to the core, and a higher source index means higher priority. The non-maskable line is served ahead of all others and ignores both the enable bits and the global enable.

The core services the presented request by pulsing `ack_i` for one cycle. That pulse clears the pending bit of the source being presented and starts a lockout. During the lockout no request is shown. The lockout ends when the core reports, with `insn_done_i`, that the first instruction after the call has retired. Requests that arrive during the lockout stay pending and are served in priority order once it ends.

Software reaches the pending and enable registers one byte at a time through a simple write port and reads them back on plain outputs. A write can set or clear pending bits directly. When a hardware transition and a software clear hit the same pending bit in the same cycle, the hardware transition wins.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A 0-to-1 change on `src_i[k]`, seen at one clock edge, sets `pend_o[k]` at that edge. A line that stays high does not set the bit again after it has been cleared.
- R2: Pending bits latch while their enable bit is 0. The request outputs do not report a disabled source.
- R3: A write with `wr_en_i=1` replaces one byte. The selects are: `wr_sel_i=0` for pending bits 7:0, 1 for pending bits 15:8, 2 for enable bits 7:0, 3 for enable bits 15:8, and 4 for the non-maskable enable bit, which takes `wr_data_i[0]` and reads back on `nmi_mask_o`.
- R4: If a hardware transition and a software write of 0 reach the same pending bit in the same cycle, the bit ends up at 1.
- R5: A maskable source is requested only when its pending bit, its enable bit (1 = enabled) and `glb_en_i` are all 1.
- R6: When several maskable sources qualify, `req_idx_o` gives the highest index, and `req_nmi_o` is 0.
- R7: A pending non-maskable interrupt is requested with `req_nmi_o=1` and `req_idx_o=0`. It is requested regardless of the enable bits, `nmi_mask_o` and `glb_en_i`, and it wins over every maskable source.
- R8: Holding `nmi_i` high produces only one non-maskable request.
- R9: An `ack_i` pulse while `req_valid_o=1` clears only the pending bit of the presented source, at that edge. An `ack_i` pulse while `req_valid_o=0` changes nothing.
- R10: After an accepted acknowledge, `req_valid_o` stays 0 until an `insn_done_i` pulse. Sources that become pending meanwhile are presented by priority after that pulse.
- R11: After reset, all pending and enable bits and `nmi_mask_o` are 0, and `req_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | 16 | Maskable interrupt lines |
| nmi_i | input | 1 | Non-maskable interrupt line |
| glb_en_i | input | 1 | Global enable for maskable sources |
| wr_en_i | input | 1 | Software byte write strobe |
| wr_sel_i | input | 3 | Byte select for the write |
| wr_data_i | input | 8 | Write data byte |
| ack_i | input | 1 | One-cycle acknowledge of the presented vector |
| insn_done_i | input | 1 | Pulse when an instruction retires, ends lockout |
| pend_o | output | 16 | Pending bits |
| mask_o | output | 16 | Enable bits |
| nmi_mask_o | output | 1 | Stored non-maskable enable bit (no effect) |
| req_valid_o | output | 1 | A request is presented |
| req_nmi_o | output | 1 | The presented request is the non-maskable one |
| req_idx_o | output | 4 | Index of the presented maskable source |

## Verification
All register updates take effect at the clock edge that samples the stimulus. This covers pending set, software write, acknowledge clear and the lockout set or release. The request outputs are combinational from the registered state and `glb_en_i`, so they settle within the same cycle. The bench therefore drives every stimulus on a falling edge and checks the results at the next falling edge, one register stage later. A change to `glb_en_i` alone is checked a moment after the change, without waiting for an edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [2:0] {
        SEL_PEND_LO = 3'd0,
        SEL_PEND_HI = 3'd1,
        SEL_MASK_LO = 3'd2,
        SEL_MASK_HI = 3'd3,
        SEL_NMI_CTL = 3'd4
    } reg_sel_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/irq_edge.sv
module irq_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_st_t;

    edge_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = lvl_i & ~st_q.prev;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic [NUM_SRC-1:0] ack_clr_i,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [BYTE_W-1:0]  wr_data_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               nmi_mask_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] mask;
        logic               nmi_mask;
    } reg_st_t;

    reg_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend & ~ack_clr_i;
        if (wr_en_i) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if ((wr_sel_i == SEL_PEND_LO && i < BYTE_W) ||
                    (wr_sel_i == SEL_PEND_HI && i >= BYTE_W))
                    st_d.pend[i] = wr_data_i[i % BYTE_W];
                if ((wr_sel_i == SEL_MASK_LO && i < BYTE_W) ||
                    (wr_sel_i == SEL_MASK_HI && i >= BYTE_W))
                    st_d.mask[i] = wr_data_i[i % BYTE_W];
            end
            if (wr_sel_i == SEL_NMI_CTL)
                st_d.nmi_mask = wr_data_i[0];
        end
        st_d.pend = st_d.pend | rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o     = st_q.pend;
    assign mask_o     = st_q.mask;
    assign nmi_mask_o = st_q.nmi_mask;

    assert_edge_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((pend_o & $past(rise_i)) == $past(rise_i)));

    assert_mask_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (mask_o == $past(mask_o)));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] act_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (act_i[i]) idx_o = IDX_W'(i);
    end

    assign any_o = |act_i;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               nmi_i,
    input  logic               glb_en_i,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [7:0]         wr_data_i,
    input  logic               ack_i,
    input  logic               insn_done_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               nmi_mask_o,
    output logic               req_valid_o,
    output logic               req_nmi_o,
    output logic [IDX_W-1:0]   req_idx_o
);
    localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

    typedef struct packed {
        logic nmi_pend;
        logic lock;
    } ctl_st_t;

    ctl_st_t st_q, st_d;

    logic [NUM_SRC-1:0] src_rise, ack_clr, active;
    logic               nmi_rise, any_act, ack_take;
    logic [IDX_W-1:0]   top_idx;

    irq_edge #(.W(NUM_SRC)) u_src_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(src_i), .rise_o(src_rise));

    irq_edge #(.W(1)) u_nmi_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(nmi_i), .rise_o(nmi_rise));

    irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .rise_i(src_rise), .ack_clr_i(ack_clr),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .pend_o(pend_o), .mask_o(mask_o), .nmi_mask_o(nmi_mask_o));

    assign active = glb_en_i ? (pend_o & mask_o) : '0;

    irq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .act_i(active), .any_o(any_act), .idx_o(top_idx));

    assign req_valid_o = !st_q.lock && (st_q.nmi_pend || any_act);
    assign req_nmi_o   = req_valid_o && st_q.nmi_pend;
    assign req_idx_o   = st_q.nmi_pend ? '0 : top_idx;
    assign ack_take    = ack_i && req_valid_o;
    assign ack_clr     = (ack_take && !st_q.nmi_pend) ? (ONE << top_idx) : '0;

    always_comb begin
        st_d = st_q;
        if (ack_take && st_q.nmi_pend) st_d.nmi_pend = 1'b0;
        if (nmi_rise)                  st_d.nmi_pend = 1'b1;
        if (ack_take)                  st_d.lock     = 1'b1;
        else if (insn_done_i)          st_d.lock     = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_lockout_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> !req_valid_o);

    assert_pick_highest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_nmi_o) |-> (((pend_o & mask_o) >> req_idx_o) == ONE));

    assert_nmi_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.nmi_pend && !st_q.lock) |-> (req_valid_o && req_nmi_o && req_idx_o == '0));

    assert_global_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en_i && !st_q.nmi_pend) |-> !req_valid_o);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !req_nmi_o && !src_rise[req_idx_o] && !wr_en_i)
        |=> !pend_o[$past(req_idx_o)]);
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_i = '0;
    logic        nmi_i = 1'b0, glb_en_i = 1'b0, wr_en_i = 1'b0;
    logic [2:0]  wr_sel_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic        ack_i = 1'b0, insn_done_i = 1'b0;
    logic [15:0] pend_o, mask_o;
    logic        nmi_mask_o, req_valid_o, req_nmi_o;
    logic [3:0]  req_idx_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .nmi_i(nmi_i), .glb_en_i(glb_en_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .ack_i(ack_i),
        .insn_done_i(insn_done_i), .pend_o(pend_o), .mask_o(mask_o),
        .nmi_mask_o(nmi_mask_o), .req_valid_o(req_valid_o), .req_nmi_o(req_nmi_o),
        .req_idx_o(req_idx_o));

    typedef struct packed {
        logic [15:0] pend;
        logic [15:0] mask;
        logic        glb;
        logic        exp_v;
        logic [3:0]  exp_idx;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h0001, 16'h0001, 1'b1, 1'b1, 4'd0},
        '{16'h8001, 16'hFFFF, 1'b1, 1'b1, 4'd15},
        '{16'h8001, 16'h7FFF, 1'b1, 1'b1, 4'd0},
        '{16'h0F00, 16'h0FFF, 1'b0, 1'b0, 4'd0},
        '{16'h0F00, 16'h0A00, 1'b1, 1'b1, 4'd11},
        '{16'h00F0, 16'h0F0F, 1'b1, 1'b0, 4'd0},
        '{16'h1234, 16'h00FF, 1'b1, 1'b1, 4'd5},
        '{16'h0240, 16'hFFFF, 1'b1, 1'b1, 4'd9}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic pulse_ack;
        @(negedge clk); ack_i = 1'b1;
        @(negedge clk); ack_i = 1'b0;
    endtask

    task automatic pulse_done;
        @(negedge clk); insn_done_i = 1'b1;
        @(negedge clk); insn_done_i = 1'b0;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 pend", pend_o, 0);
        chk("R11 mask", mask_o, 0);
        chk("R11 nmi_mask", nmi_mask_o, 0);
        chk("R11 valid", req_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            wr(3'd0, VECS[v].pend[7:0]);
            wr(3'd1, VECS[v].pend[15:8]);
            wr(3'd2, VECS[v].mask[7:0]);
            wr(3'd3, VECS[v].mask[15:8]);
            glb_en_i = VECS[v].glb;
            #1;
            chk("R3 pend readback", pend_o, VECS[v].pend);
            chk("R3 mask readback", mask_o, VECS[v].mask);
            chk("R5 valid", req_valid_o, VECS[v].exp_v);
            if (VECS[v].exp_v) chk("R6 index", req_idx_o, VECS[v].exp_idx);
        end

        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        glb_en_i = 1'b1;

        // R1 / R2: edge sets pending while masked
        @(negedge clk); src_i[6] = 1'b1;
        @(negedge clk);
        chk("R1 edge sets pend", pend_o, 16'h0040);
        chk("R2 masked no request", req_valid_o, 0);
        wr(3'd0, 8'h00);
        @(negedge clk);
        chk("R1 held level no reset", pend_o, 16'h0000);
        src_i[6] = 1'b0;

        // R4: hardware set beats software clear
        @(negedge clk);
        src_i[3] = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 8'h00;
        @(negedge clk);
        wr_en_i = 1'b0; src_i[3] = 1'b0;
        chk("R4 set wins", pend_o, 16'h0008);

        // R9 / R10
        wr(3'd1, 8'h04);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        glb_en_i = 1'b0;
        pulse_ack();
        chk("R9 ignored ack pend", pend_o, 16'h0408);
        glb_en_i = 1'b1; #1;
        chk("R9 ignored ack no lock", req_valid_o, 1);
        chk("R6 idx10", req_idx_o, 10);
        pulse_ack();
        chk("R9 clears presented", pend_o, 16'h0008);
        chk("R10 locked", req_valid_o, 0);
        @(negedge clk); src_i[12] = 1'b1;
        @(negedge clk); src_i[12] = 1'b0;
        chk("R10 pend during lockout", pend_o, 16'h1008);
        chk("R10 still locked", req_valid_o, 0);
        pulse_done();
        chk("R10 released", req_valid_o, 1);
        chk("R10 priority after lockout", req_idx_o, 12);
        pulse_ack(); pulse_done();
        chk("R9 next idx3", req_idx_o, 3);
        pulse_ack(); pulse_done();
        chk("R9 all served", req_valid_o, 0);
        chk("R9 pend empty", pend_o, 0);

        // R7 / R8
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        glb_en_i = 1'b0;
        wr(3'd4, 8'h01);
        chk("R3 nmi mask bit", nmi_mask_o, 1);
        @(negedge clk); nmi_i = 1'b1;
        @(negedge clk);
        chk("R7 nmi valid", req_valid_o, 1);
        chk("R7 nmi flag", req_nmi_o, 1);
        chk("R7 nmi idx", req_idx_o, 0);
        pulse_ack();
        chk("R10 nmi lock", req_valid_o, 0);
        pulse_done();
        chk("R8 held nmi once", req_valid_o, 0);
        nmi_i = 1'b0;
        wr(3'd1, 8'h80); wr(3'd3, 8'h80);
        glb_en_i = 1'b1;
        @(negedge clk); nmi_i = 1'b1;
        @(negedge clk);
        chk("R7 nmi beats 15", req_nmi_o, 1);
        pulse_ack();
        chk("R9 only nmi cleared", pend_o, 16'h8000);
        pulse_done();
        chk("R7 then idx15 valid", req_valid_o, 1);
        chk("R7 then idx15 not nmi", req_nmi_o, 0);
        chk("R6 idx15", req_idx_o, 15);

        finish_run();
    end
endmodule